// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder

This block adds or subtracts two 32-bit single-precision floating-point words. Each operand has a sign bit, an 8-bit biased exponent and a 23-bit fraction. A select input turns the addition into a subtraction by inverting the sign of the second operand. Any cycle can start a new operation. The result appears exactly three clock cycles later, qualified by an output valid, together with an overflow flag and an underflow flag.

The work is split over three register stages:

- **Stage 1** unpacks both words, finds the operand of larger magnitude and computes the exponent difference.
- **Stage 2** shifts the smaller significand right by that difference. It keeps three extra low-order positions (guard, round and a sticky OR of everything shifted past them), then adds or subtracts the significands.
- **Stage 3** normalizes the sum, rounds to nearest with ties to even, and packs the word.

Inputs with a zero exponent field count as zero, and results too small for the normal range are flushed to zero. Infinities and NaNs take a bypass path.

Top module: `fp_adder_top`

## Requirements
- R1: For two finite normal operands with `op_sub`=0, `result` is the exact sum rounded to nearest-even into a word with sign at bit 31, a biased exponent (bias 127) in bits 30:23 and a fraction in bits 22:0. For example, 0x3F000000 + 0xBEE00000 gives 0x3D800000 (biased exponent 123, fraction 0).
- R2: `op_sub`=1 produces a − b, meaning b is used with its sign bit inverted.
- R3: An operand whose exponent field is 0 is treated as a zero of that sign, whatever its fraction bits hold.
- R4: Alignment keeps guard, round and sticky information, so a sum exactly halfway between two representable values rounds to the one with an even last fraction bit. For example, 0x3F800000 + 0x33800000 gives 0x3F800000, and 0x3F800001 + 0x33800000 gives 0x3F800002.
- R5: When rounding carries out of the 24-bit significand, the exponent rises by one and the fraction becomes 0. For example, 0x3FFFFFFF + 0x33800000 gives 0x40000000.
- R6: A rounded biased exponent of 255 or more yields an infinity of the result's sign (exponent field all ones, fraction 0) with `overflow`=1. `overflow` and `underflow` are never both 1.
- R7: A rounded biased exponent of 0 or less (unbiased exponent below −126) yields a zero of the result's sign with `underflow`=1.
- R8: An exactly zero sum gives +0, except when both effective operand signs are negative, which gives −0. Both flags stay 0 in this case.
- R9: A NaN operand (exponent all ones, nonzero fraction) is forwarded with fraction bit 22 forced to 1. If both operands are NaN, `a` takes priority. Both flags stay 0.
- R10: An infinite operand passes to the result with its effective sign. Two infinities with opposite effective signs give 0x7FC00000.
- R11: `valid_out` rises exactly three clock cycles after each accepted `valid_in`, one output per input and in order. While `rst` is high, `valid_out`, `result` and both flags read 0.
- R12: Heavy cancellation is renormalized by a left shift with a matching exponent decrement. For example, 0x3F800000 − 0x3F7FFFFF gives 0x33800000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| valid_in | input | 1 | Operands and select are taken this cycle |
| op_sub | input | 1 | 1 selects a − b, 0 selects a + b |
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| valid_out | output | 1 | Result word and flags are valid |
| result | output | 32 | Rounded result word |
| overflow | output | 1 | Result saturated to infinity |
| underflow | output | 1 | Result flushed to zero |

## Verification
Every result, flag and `valid_out` pulse is due three rising edges after the edge that captures its operands. The bench drives each operation 2 ns after a rising edge and records a due cycle equal to the current edge count plus three. It samples the outputs on the falling edge and requires that every `valid_out` pulse lands on exactly the due cycle of the oldest pending operation. The expected word and flags come from an exact wide-integer sum, rounded with a full remainder comparison rather than a three-bit window. Directed cases cover the ties, the carry-out, the cancellation and the special values, and randomized operands with nearby exponents fill in the rest.

// File: rtl/fpa_pkg.sv
package fpa_pkg;

    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int SIG_W  = FRAC_W + 1;
    localparam int EXT_W  = SIG_W + 3;
    localparam int SUM_W  = EXT_W + 1;
    localparam int LZ_W   = $clog2(EXT_W + 1);
    localparam int EXPS_W = EXP_W + 2;
    localparam int EXP_ONES = (1 << EXP_W) - 1;

    localparam logic [WORD_W-1:0] QUIET_MASK = WORD_W'(1) << (FRAC_W - 1);
    localparam logic [WORD_W-1:0] DEFAULT_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] exp;
        logic [SIG_W-1:0] sig;
    } unpacked_t;

    typedef struct packed {
        logic              valid;
        logic              special;
        logic [WORD_W-1:0] spec_word;
        logic              sign;
        logic              zero_sign;
        logic              eff_sub;
        logic [EXP_W-1:0]  exp;
        logic [EXP_W-1:0]  diff;
        logic [SIG_W-1:0]  big_sig;
        logic [SIG_W-1:0]  small_sig;
    } cmp_stage_t;

    typedef struct packed {
        logic              valid;
        logic              special;
        logic [WORD_W-1:0] spec_word;
        logic              sign;
        logic              zero_sign;
        logic              eff_sub;
        logic [EXP_W-1:0]  exp;
        logic [SUM_W-1:0]  sum;
    } add_stage_t;

    function automatic unpacked_t unpack_word(input logic [WORD_W-1:0] w);
        unpacked_t u;
        u.sign = w[WORD_W-1];
        u.exp  = w[WORD_W-2 -: EXP_W];
        u.sig  = (u.exp == '0) ? '0 : {1'b1, w[FRAC_W-1:0]};
        return u;
    endfunction

    function automatic logic [LZ_W-1:0] lead_zeros(input logic [EXT_W-1:0] v);
        logic [LZ_W-1:0] n;
        logic            seen;
        n    = '0;
        seen = 1'b0;
        for (int i = EXT_W - 1; i >= 0; i--) begin
            if (!seen) begin
                if (v[i]) seen = 1'b1;
                else      n    = n + LZ_W'(1);
            end
        end
        return n;
    endfunction

endpackage

// File: rtl/fpa_compare.sv
module fpa_compare
    import fpa_pkg::*;
(
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    input  logic              op_sub,
    output cmp_stage_t        cmp
);
    unpacked_t ua, ub;
    logic      sb_eff;
    logic      a_max, b_max, a_nan, b_nan, a_inf, b_inf;
    logic      a_big;

    always_comb begin
        ua     = unpack_word(a);
        ub     = unpack_word(b);
        sb_eff = ub.sign ^ op_sub;
        a_max  = (ua.exp == EXP_W'(EXP_ONES));
        b_max  = (ub.exp == EXP_W'(EXP_ONES));
        a_nan  = a_max && (a[FRAC_W-1:0] != '0);
        b_nan  = b_max && (b[FRAC_W-1:0] != '0);
        a_inf  = a_max && !a_nan;
        b_inf  = b_max && !b_nan;
        a_big  = {ua.exp, ua.sig} >= {ub.exp, ub.sig};

        cmp           = '0;
        cmp.valid     = 1'b0;
        cmp.special   = a_max || b_max;
        if (a_nan)
            cmp.spec_word = a | QUIET_MASK;
        else if (b_nan)
            cmp.spec_word = b | QUIET_MASK;
        else if (a_inf && b_inf)
            cmp.spec_word = (ua.sign != sb_eff) ? DEFAULT_NAN : a;
        else if (a_inf)
            cmp.spec_word = a;
        else if (b_inf)
            cmp.spec_word = {sb_eff, b[WORD_W-2:0]};

        cmp.eff_sub   = ua.sign ^ sb_eff;
        cmp.zero_sign = ua.sign & sb_eff;
        if (a_big) begin
            cmp.sign      = ua.sign;
            cmp.exp       = ua.exp;
            cmp.diff      = ua.exp - ub.exp;
            cmp.big_sig   = ua.sig;
            cmp.small_sig = ub.sig;
        end else begin
            cmp.sign      = sb_eff;
            cmp.exp       = ub.exp;
            cmp.diff      = ub.exp - ua.exp;
            cmp.big_sig   = ub.sig;
            cmp.small_sig = ua.sig;
        end
    end
endmodule

// File: rtl/fpa_align_add.sv
module fpa_align_add
    import fpa_pkg::*;
(
    input  cmp_stage_t cmp,
    output add_stage_t add
);
    logic [EXT_W-1:0] small_ext, big_ext, shifted, lost_mask, aligned;
    logic             sticky;

    always_comb begin
        small_ext = {cmp.small_sig, 3'b000};
        big_ext   = {cmp.big_sig, 3'b000};
        if (cmp.diff >= EXP_W'(EXT_W)) begin
            shifted   = '0;
            lost_mask = '1;
        end else begin
            shifted   = small_ext >> cmp.diff;
            lost_mask = (EXT_W'(1) << cmp.diff) - EXT_W'(1);
        end
        sticky  = |(small_ext & lost_mask);
        aligned = {shifted[EXT_W-1:1], shifted[0] | sticky};

        add.valid     = cmp.valid;
        add.special   = cmp.special;
        add.spec_word = cmp.spec_word;
        add.sign      = cmp.sign;
        add.zero_sign = cmp.zero_sign;
        add.eff_sub   = cmp.eff_sub;
        add.exp       = cmp.exp;
        if (cmp.eff_sub)
            add.sum = {1'b0, big_ext} - {1'b0, aligned};
        else
            add.sum = {1'b0, big_ext} + {1'b0, aligned};
    end
endmodule

// File: rtl/fpa_norm_round.sv
module fpa_norm_round
    import fpa_pkg::*;
(
    input  add_stage_t        add,
    output logic [WORD_W-1:0] word,
    output logic              ovf,
    output logic              udf
);
    logic signed [EXPS_W-1:0] e;
    logic [EXT_W-1:0]         norm;
    logic [LZ_W-1:0]          lz;
    logic [SIG_W-1:0]         mant;
    logic [SIG_W:0]           mant_r;
    logic                     guard_b, rest_b, round_up;

    always_comb begin
        ovf      = 1'b0;
        udf      = 1'b0;
        e        = $signed({2'b00, add.exp});
        lz       = '0;
        norm     = add.sum[EXT_W-1:0];
        if (add.sum[SUM_W-1]) begin
            norm = {add.sum[SUM_W-1:2], add.sum[1] | add.sum[0]};
            e    = e + $signed(EXPS_W'(1));
        end else begin
            lz   = lead_zeros(add.sum[EXT_W-1:0]);
            norm = add.sum[EXT_W-1:0] << lz;
            e    = e - $signed(EXPS_W'(lz));
        end
        mant     = norm[EXT_W-1:3];
        guard_b  = norm[2];
        rest_b   = norm[1] | norm[0];
        round_up = guard_b & (rest_b | mant[0]);
        mant_r   = {1'b0, mant} + (SIG_W+1)'(round_up);
        if (mant_r[SIG_W]) begin
            mant_r = mant_r >> 1;
            e      = e + $signed(EXPS_W'(1));
        end

        if (add.special) begin
            word = add.spec_word;
        end else if (add.sum == '0) begin
            word = {add.zero_sign, {(WORD_W-1){1'b0}}};
        end else if (e >= $signed(EXPS_W'(EXP_ONES))) begin
            ovf  = 1'b1;
            word = {add.sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        end else if (e < $signed(EXPS_W'(1))) begin
            udf  = 1'b1;
            word = {add.sign, {(WORD_W-1){1'b0}}};
        end else begin
            word = {add.sign, e[EXP_W-1:0], mant_r[FRAC_W-1:0]};
        end
    end
endmodule

// File: rtl/fp_adder_top.sv
module fp_adder_top
    import fpa_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_in,
    input  logic              op_sub,
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    output logic              valid_out,
    output logic [WORD_W-1:0] result,
    output logic              overflow,
    output logic              underflow
);
    cmp_stage_t        cmp_d, cmp_q;
    add_stage_t        add_d, add_q;
    logic [WORD_W-1:0] word_d;
    logic              ovf_d, udf_d;

    fpa_compare u_compare (.a(a), .b(b), .op_sub(op_sub), .cmp(cmp_d));
    fpa_align_add u_align_add (.cmp(cmp_q), .add(add_d));
    fpa_norm_round u_norm_round (.add(add_q), .word(word_d), .ovf(ovf_d), .udf(udf_d));

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q     <= '0;
            add_q     <= '0;
            valid_out <= 1'b0;
            result    <= '0;
            overflow  <= 1'b0;
            underflow <= 1'b0;
        end else begin
            cmp_q       <= cmp_d;
            cmp_q.valid <= valid_in;
            add_q       <= add_d;
            valid_out   <= add_q.valid;
            result      <= word_d;
            overflow    <= ovf_d;
            underflow   <= udf_d;
        end
    end

    logic [1:0] rst_age;
    always_ff @(posedge clk) begin
        if (rst)                 rst_age <= '0;
        else if (rst_age != 2'd3) rst_age <= rst_age + 2'd1;
    end

    assert_latency_R11: assert property (@(posedge clk) disable iff (rst)
        (rst_age == 2'd3) |-> (valid_out == $past(valid_in, 3)));

    assert_ovf_inf_R6: assert property (@(posedge clk) disable iff (rst)
        (valid_out && overflow) |-> (result[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));

    assert_flag_excl_R6: assert property (@(posedge clk) disable iff (rst)
        !(overflow && underflow));

    assert_udf_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (valid_out && underflow) |-> (result[WORD_W-2:0] == '0));

    assert_order_R4: assert property (@(posedge clk) disable iff (rst)
        (cmp_q.valid && !cmp_q.special && cmp_q.diff == '0) |-> (cmp_q.big_sig >= cmp_q.small_sig));

    assert_sub_nocarry_R2: assert property (@(posedge clk) disable iff (rst)
        (add_q.valid && add_q.eff_sub) |-> !add_q.sum[SUM_W-1]);
endmodule

// File: tb/fp_adder_top_bench.sv
module fp_adder_top_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_in = 1'b0;
    logic        op_sub = 1'b0;
    logic [31:0] a = '0, b = '0;
    logic        valid_out, overflow, underflow;
    logic [31:0] result;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    logic [33:0] exp_q[$];
    int          due_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fp_adder_top u_fp_adder_top (
        .clk(clk), .rst(rst), .valid_in(valid_in), .op_sub(op_sub), .a(a), .b(b),
        .valid_out(valid_out), .result(result), .overflow(overflow), .underflow(underflow)
    );

    task automatic check(input bit ok, input string req, input logic [33:0] act, input logic [33:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Returns {overflow, underflow, word}, from an exact wide-integer sum.
    function automatic logic [33:0] ref_add(input logic [31:0] x, input logic [31:0] y, input logic sub);
        logic sx, sy, sres;
        int ex, ey, emin, p, e_true, bexp, sh;
        logic [23:0]  gx, gy;
        logic [299:0] vx, vy, mag, m, rem, half, one;
        bit found;
        one = 300'd1;
        sx = x[31];
        sy = y[31] ^ sub;
        ex = int'(x[30:23]);
        ey = int'(y[30:23]);
        if (ex == 255 && x[22:0] != 0) return {2'b00, x | 32'h0040_0000};
        if (ey == 255 && y[22:0] != 0) return {2'b00, y | 32'h0040_0000};
        if (ex == 255 && ey == 255) return (sx != sy) ? {2'b00, 32'h7FC0_0000} : {2'b00, x};
        if (ex == 255) return {2'b00, x};
        if (ey == 255) return {2'b00, sy, y[30:0]};
        gx = (ex == 0) ? 24'd0 : {1'b1, x[22:0]};
        gy = (ey == 0) ? 24'd0 : {1'b1, y[22:0]};
        if (gx == 0 && gy == 0) return {2'b00, sx & sy, 31'd0};
        if (gx == 0)      emin = ey;
        else if (gy == 0) emin = ex;
        else              emin = (ex < ey) ? ex : ey;
        vx = (gx == 0) ? '0 : ({276'd0, gx} << (ex - emin));
        vy = (gy == 0) ? '0 : ({276'd0, gy} << (ey - emin));
        if (sx == sy) begin
            mag = vx + vy; sres = sx;
        end else if (vx >= vy) begin
            mag = vx - vy; sres = sx;
        end else begin
            mag = vy - vx; sres = sy;
        end
        if (mag == 0) return {2'b00, sx & sy, 31'd0};
        p = 0; found = 0;
        for (int i = 299; i >= 0; i--) begin
            if (!found && mag[i]) begin p = i; found = 1; end
        end
        e_true = p + emin - 150;
        if (p > 23) begin
            sh   = p - 23;
            m    = mag >> sh;
            rem  = mag & ((one << sh) - one);
            half = one << (sh - 1);
            if (rem > half || (rem == half && m[0])) m = m + one;
        end else begin
            m = mag << (23 - p);
        end
        if (m[24]) begin
            m = m >> 1;
            e_true++;
        end
        bexp = e_true + 127;
        if (bexp >= 255) return {2'b10, sres, 8'hFF, 23'd0};
        if (bexp <= 0)   return {2'b01, sres, 31'd0};
        return {2'b00, sres, bexp[7:0], m[22:0]};
    endfunction

    task automatic send(input logic [31:0] x, input logic [31:0] y, input logic s, input string tag);
        @(posedge clk);
        #2;
        a = x; b = y; op_sub = s; valid_in = 1'b1;
        exp_q.push_back(ref_add(x, y, s));
        due_q.push_back(cyc + 3);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
            valid_in = 1'b0;
        end
    endtask

    always @(negedge clk) begin
        if (!rst && valid_out) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R11 unexpected valid_out", {overflow, underflow, result}, '0);
            end else begin
                logic [33:0] e;
                int          d;
                string       t;
                e = exp_q.pop_front();
                d = due_q.pop_front();
                t = tag_q.pop_front();
                check(d == cyc, "R11 latency", 34'(cyc), 34'(d));
                check({overflow, underflow, result} == e, t, {overflow, underflow, result}, e);
            end
        end
    end

    initial begin
        #(20 * 150000);
        check(1'b0, "watchdog", '0, '0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] x, y;
        repeat (3) @(posedge clk);
        #2;
        check(valid_out == 1'b0 && result == '0 && !overflow && !underflow,
              "R11 reset state", {overflow, underflow, result}, '0);
        rst = 1'b0;

        send(32'h3F80_0000, 32'h3F80_0000, 1'b0, "R1 one plus one");
        send(32'h3F00_0000, 32'hBEE0_0000, 1'b0, "R1 half minus 0.4375");
        send(32'h40A0_0000, 32'h3F40_0000, 1'b0, "R1 five plus 0.75");
        send(32'h3F00_0000, 32'h3EE0_0000, 1'b1, "R2 subtract select");
        send(32'h4040_0000, 32'hC000_0000, 1'b1, "R2 subtract of negative");
        idle(2);
        send(32'h3F80_0000, 32'h0000_1234, 1'b0, "R3 denormal b is zero");
        send(32'h8012_3456, 32'hC020_0000, 1'b0, "R3 denormal a is zero");
        send(32'h3F80_0000, 32'h3380_0000, 1'b0, "R4 tie stays even");
        send(32'h3F80_0001, 32'h3380_0000, 1'b0, "R4 tie rounds to even");
        send(32'h3F80_0000, 32'h3380_0001, 1'b0, "R4 above half rounds up");
        send(32'h3F80_0000, 32'h2F80_0000, 1'b0, "R4 far shift sticky only");
        send(32'h3FFF_FFFF, 32'h3380_0000, 1'b0, "R5 rounding carry out");
        send(32'h7F7F_FFFF, 32'h7F7F_FFFF, 1'b0, "R6 overflow positive");
        send(32'hFF7F_FFFF, 32'h7F7F_FFFF, 1'b1, "R6 overflow negative");
        send(32'h0080_0001, 32'h0080_0000, 1'b1, "R7 underflow positive");
        send(32'h8080_0001, 32'h8080_0000, 1'b1, "R7 underflow negative");
        send(32'h3F80_0000, 32'h3F80_0000, 1'b1, "R8 exact cancel");
        send(32'h8000_0000, 32'h8000_0000, 1'b0, "R8 negative zeros");
        send(32'hBF80_0000, 32'h3F80_0000, 1'b0, "R8 cancel negative first");
        send(32'h7F80_0001, 32'h3F80_0000, 1'b0, "R9 NaN a quieted");
        send(32'h3F80_0000, 32'hFF80_0010, 1'b1, "R9 NaN b forwarded");
        send(32'h7F80_0002, 32'h7FA0_0000, 1'b0, "R9 both NaN a wins");
        send(32'h7F80_0000, 32'h3F80_0000, 1'b0, "R10 inf passes");
        send(32'h3F80_0000, 32'h7F80_0000, 1'b1, "R10 minus inf");
        send(32'h7F80_0000, 32'h7F80_0000, 1'b1, "R10 inf minus inf");
        send(32'hFF80_0000, 32'hFF80_0000, 1'b0, "R10 same sign infs");
        send(32'h3F80_0000, 32'h3F7F_FFFF, 1'b1, "R12 deep cancel");
        send(32'h4B00_0001, 32'h4B00_0000, 1'b1, "R12 cancel to one");
        idle(5);

        for (int i = 0; i < 1500; i++) begin
            x = $urandom();
            y = $urandom();
            if (i % 3 == 0) y[30:23] = x[30:23] + 8'($urandom_range(0, 3)) - 8'd1;
            if (i % 7 == 0) y[30:0] = x[30:0] ^ 31'($urandom_range(0, 7));
            send(x, y, 1'($urandom_range(0, 1)), (i % 2 == 0) ? "R1 random" : "R2 random");
            if (i % 11 == 0) idle(1 + $urandom_range(0, 2));
        end
        idle(6);
        check(exp_q.size() == 0, "R11 all results delivered", 34'(exp_q.size()), '0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule